// File: doc/BRIEF.md
# Direct Sound Sample FIFO Pair

This block serves two streaming sample channels, named A and B, that feed signed 8-bit audio samples to a playback engine. Each channel has its own 32-deep sample queue. A producer, normally a DMA engine, loads a queue with 16-bit writes to the channel's port. Each such write puts two samples into the queue. The playback side takes one sample from a queue on each playback tick for that channel. The sample it takes stays on the channel's sample output until the next tick.

Both channels share one 16-bit control word. For each channel the word holds a volume choice (half or full), right and left output enables, and a choice between two timers. The same word also carries two write-one strobes that flush the queues.

The block also turns timer overflow pulses into refill requests. When the master enable is high, each channel whose selected timer overflows raises a one-cycle request. The request carries that channel's port address, so a DMA engine can top the queue up. Mixing and analogue output lie outside the block.

Top module: `dsound_fifo_pair`

## Requirements
- R1: After reset the control readback is 0, both sample outputs are 0, no request is raised, and both queues are empty.
- R2: A port write accepted in cycle N queues bits [7:0] in cycle N and bits [15:8] in cycle N+1. Samples leave the queue in the order they entered. A pop tick in cycle M updates that channel's sample output after the edge of cycle M, and the output holds until the next tick.
- R3: A queue holds at most 32 samples. A push into a full queue is dropped, and no stored sample is overwritten.
- R4: A pop from an empty queue drives the sample output to 0 and moves no pointer. A sample queued later is still the next one popped.
- R5: The control readback returns the stored value of eight bits and 0 in every other bit:
  - bit 2 is the volume of A and bit 3 is the volume of B (0 = half, 1 = full);
  - bits 8 and 9 are the right and left enables of A, and bit 10 is the timer select of A;
  - bits 12, 13 and 14 are the same three bits for B.
  - Writing 0xFFFF therefore reads back 0x770C.
- R6: Writing a 1 to bit 11 of the control word empties queue A, and a 1 to bit 15 empties queue B. The flush also discards any pending high byte and any push or pop in that cycle. The other queue is untouched.
- R7: With master enable high, a pulse on timer input T in cycle N raises the request of every channel whose timer select equals T, in cycle N+1, for one cycle. During that cycle the request address output carries the channel's port address (parameters FIFO_A_ADDR and FIFO_B_ADDR). Otherwise the address output is 0.
- R8: While master enable is low, timer pulses raise no request.
- R9: A write to a channel's port in the cycle its high byte is still pending is dropped entirely.
- R10: The two channels are independent. Traffic, flushes and ticks on one channel never change the other channel's queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| masterEn | input | 1 | Master sound enable, gates request generation |
| ctrlWrEn | input | 1 | Control word write strobe |
| ctrlWrData | input | 16 | Control word write data |
| ctrlRdData | output | 16 | Control word readback |
| fifoWrEn | input | 2 | Port write strobe per channel (bit 0 = A, bit 1 = B) |
| fifoWrData | input | 16 | Port write data, two samples |
| popTick | input | 2 | Playback tick per channel |
| sampleA | output | 8 | Last sample taken from queue A (two's complement) |
| sampleB | output | 8 | Last sample taken from queue B (two's complement) |
| timerOvf | input | 2 | Overflow pulse of timer 0 (bit 0) and timer 1 (bit 1) |
| reqValid | output | 2 | Refill request per channel |
| reqAddrA | output | ADDR_W | Port address of A while its request is high, else 0 |
| reqAddrB | output | ADDR_W | Port address of B while its request is high, else 0 |

## Verification
The bound checker watches several properties on every cycle:
- the fill level never goes past the depth, and a full queue keeps its level when a push arrives;
- an empty pop leaves the level at zero and the output at zero, and a flush strobe empties its queue;
- a high byte is only pushed in the cycle right after a low byte;
- requests appear only after a timer pulse and never while master enable was low, and the request addresses match the request lines.

Only the directed scenarios can show data order across the byte split, the exact readback mask, the effect of timer-select routing, the dropped back-to-back write, and whether one channel's flush leaves the other's data intact.

// File: rtl/dsound_pkg.sv
package dsound_pkg;

  localparam int NCH      = 2;
  localparam int NTIMER   = 2;
  localparam int SAMPLE_W = 8;
  localparam int WORD_W   = 16;

  // Bits of the control word that hold state and read back.
  localparam logic [WORD_W-1:0] CTRL_KEEP_MASK = 16'h770C;

  // Per-channel strobes from control to datapath.
  typedef struct packed {
    logic clear;
    logic pushLo;
    logic pushHi;
    logic pop;
  } chStrobe_t;

  function automatic int volPos(input int ch);
    return 2 + ch;
  endfunction

  function automatic int rightPos(input int ch);
    return 8 + 4 * ch;
  endfunction

  function automatic int leftPos(input int ch);
    return 9 + 4 * ch;
  endfunction

  function automatic int tselPos(input int ch);
    return 10 + 4 * ch;
  endfunction

  function automatic int flushPos(input int ch);
    return 11 + 4 * ch;
  endfunction

endpackage

// File: rtl/dsound_fifo.sv
module dsound_fifo #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  logic              push,
  input  logic [DATA_W-1:0] pushData,
  input  logic              pop,
  output logic [DATA_W-1:0] popData,
  output logic [CNT_W-1:0]  fill
);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic              isFull;
  logic              isEmpty;
  logic              doPush;
  logic              doPop;

  assign isFull  = (fill == CNT_W'(DEPTH));
  assign isEmpty = (fill == '0);
  assign doPush  = push && !isFull && !clear;
  assign doPop   = pop && !isEmpty && !clear;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) store[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      fill    <= '0;
      popData <= '0;
    end else if (clear) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      fill    <= '0;
      if (pop) popData <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      fill <= fill + 1'b1;
      else if (doPop && !doPush) fill <= fill - 1'b1;
      if (pop) popData <= doPop ? store[rdPtr] : '0;
    end
  end

endmodule

// File: rtl/dsound_datapath.sv
module dsound_datapath
  import dsound_pkg::*;
#(
  parameter int DEPTH  = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  chStrobe_t [NCH-1:0]              strobes,
  input  logic [WORD_W-1:0]                fifoWrData,
  output logic [NCH-1:0][SAMPLE_W-1:0]     samples,
  output logic [NCH-1:0][CNT_W-1:0]        fillLvl
);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [SAMPLE_W-1:0] hiHold;
    logic [SAMPLE_W-1:0] pushData;
    logic                push;

    always_ff @(posedge clk) begin
      if (!rstN)                   hiHold <= '0;
      else if (strobes[ch].pushLo) hiHold <= fifoWrData[WORD_W-1:SAMPLE_W];
    end

    assign push     = strobes[ch].pushLo || strobes[ch].pushHi;
    assign pushData = strobes[ch].pushLo ? fifoWrData[SAMPLE_W-1:0] : hiHold;

    dsound_fifo #(
      .DEPTH (DEPTH),
      .DATA_W(SAMPLE_W)
    ) u_fifo (
      .clk     (clk),
      .rstN    (rstN),
      .clear   (strobes[ch].clear),
      .push    (push),
      .pushData(pushData),
      .pop     (strobes[ch].pop),
      .popData (samples[ch]),
      .fill    (fillLvl[ch])
    );
  end

endmodule

// File: rtl/dsound_ctrl.sv
module dsound_ctrl
  import dsound_pkg::*;
#(
  parameter int ADDR_W                   = 32,
  parameter logic [ADDR_W-1:0] FIFO_A_ADDR = 32'h0000_1000,
  parameter logic [ADDR_W-1:0] FIFO_B_ADDR = 32'h0000_1004
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  masterEn,
  input  logic                  ctrlWrEn,
  input  logic [WORD_W-1:0]     ctrlWrData,
  output logic [WORD_W-1:0]     ctrlRdData,
  input  logic [NCH-1:0]        fifoWrEn,
  input  logic [NCH-1:0]        popTick,
  input  logic [NTIMER-1:0]     timerOvf,
  output chStrobe_t [NCH-1:0]   strobes,
  output logic [NCH-1:0]        reqValid,
  output logic [ADDR_W-1:0]     reqAddrA,
  output logic [ADDR_W-1:0]     reqAddrB
);

  logic [WORD_W-1:0] ctrlReg;
  logic [NCH-1:0]    reqNext;

  always_ff @(posedge clk) begin
    if (!rstN)         ctrlReg <= '0;
    else if (ctrlWrEn) ctrlReg <= ctrlWrData & CTRL_KEEP_MASK;
  end

  assign ctrlRdData = ctrlReg;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam int FLUSH = flushPos(ch);
    localparam int TSEL  = tselPos(ch);

    logic pendHi;
    logic flushNow;
    logic acceptWr;

    assign flushNow = ctrlWrEn && ctrlWrData[FLUSH];
    assign acceptWr = fifoWrEn[ch] && !pendHi;

    always_ff @(posedge clk) begin
      if (!rstN)         pendHi <= 1'b0;
      else if (flushNow) pendHi <= 1'b0;
      else               pendHi <= acceptWr;
    end

    assign strobes[ch].clear  = flushNow;
    assign strobes[ch].pushLo = acceptWr && !flushNow;
    assign strobes[ch].pushHi = pendHi && !flushNow;
    assign strobes[ch].pop    = popTick[ch];

    assign reqNext[ch] = masterEn && timerOvf[ctrlReg[TSEL]];
  end

  always_ff @(posedge clk) begin
    if (!rstN) reqValid <= '0;
    else       reqValid <= reqNext;
  end

  assign reqAddrA = reqValid[0] ? FIFO_A_ADDR : '0;
  assign reqAddrB = reqValid[1] ? FIFO_B_ADDR : '0;

endmodule

// File: rtl/dsound_fifo_pair.sv
module dsound_fifo_pair
  import dsound_pkg::*;
#(
  parameter int DEPTH                       = 32,
  parameter int ADDR_W                      = 32,
  parameter logic [ADDR_W-1:0] FIFO_A_ADDR = 32'h0000_1000,
  parameter logic [ADDR_W-1:0] FIFO_B_ADDR = 32'h0000_1004
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              masterEn,
  input  logic              ctrlWrEn,
  input  logic [15:0]       ctrlWrData,
  output logic [15:0]       ctrlRdData,
  input  logic [1:0]        fifoWrEn,
  input  logic [15:0]       fifoWrData,
  input  logic [1:0]        popTick,
  output logic [7:0]        sampleA,
  output logic [7:0]        sampleB,
  input  logic [1:0]        timerOvf,
  output logic [1:0]        reqValid,
  output logic [ADDR_W-1:0] reqAddrA,
  output logic [ADDR_W-1:0] reqAddrB
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  chStrobe_t [NCH-1:0]              strobes;
  logic [NCH-1:0][SAMPLE_W-1:0]     samples;
  logic [NCH-1:0][CNT_W-1:0]        fillLvl;

  dsound_ctrl #(
    .ADDR_W     (ADDR_W),
    .FIFO_A_ADDR(FIFO_A_ADDR),
    .FIFO_B_ADDR(FIFO_B_ADDR)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .masterEn  (masterEn),
    .ctrlWrEn  (ctrlWrEn),
    .ctrlWrData(ctrlWrData),
    .ctrlRdData(ctrlRdData),
    .fifoWrEn  (fifoWrEn),
    .popTick   (popTick),
    .timerOvf  (timerOvf),
    .strobes   (strobes),
    .reqValid  (reqValid),
    .reqAddrA  (reqAddrA),
    .reqAddrB  (reqAddrB)
  );

  dsound_datapath #(
    .DEPTH(DEPTH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .fifoWrData(fifoWrData),
    .samples   (samples),
    .fillLvl   (fillLvl)
  );

  assign sampleA = samples[0];
  assign sampleB = samples[1];

endmodule

// File: rtl/dsound_checker.sv
module dsound_checker
  import dsound_pkg::*;
#(
  parameter int DEPTH                       = 32,
  parameter int ADDR_W                      = 32,
  parameter logic [ADDR_W-1:0] FIFO_A_ADDR = 32'h0000_1000,
  parameter logic [ADDR_W-1:0] FIFO_B_ADDR = 32'h0000_1004,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         masterEn,
  input logic [15:0]                  ctrlRdData,
  input logic [1:0]                   timerOvf,
  input logic [1:0]                   reqValid,
  input logic [ADDR_W-1:0]            reqAddrA,
  input logic [ADDR_W-1:0]            reqAddrB,
  input chStrobe_t [NCH-1:0]          strobes,
  input logic [NCH-1:0][SAMPLE_W-1:0] samples,
  input logic [NCH-1:0][CNT_W-1:0]    fillLvl
);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    // R3
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
      fillLvl[ch] <= CNT_W'(DEPTH));

    // R3
    a_r3_full_holds: assert property (@(posedge clk) disable iff (!rstN)
      (fillLvl[ch] == CNT_W'(DEPTH) && (strobes[ch].pushLo || strobes[ch].pushHi)
       && !strobes[ch].pop && !strobes[ch].clear)
      |=> fillLvl[ch] == CNT_W'(DEPTH));

    // R4
    a_r4_empty_pop_zero: assert property (@(posedge clk) disable iff (!rstN)
      (fillLvl[ch] == '0 && strobes[ch].pop && !strobes[ch].pushLo && !strobes[ch].pushHi)
      |=> (fillLvl[ch] == '0 && samples[ch] == '0));

    // R6
    a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
      strobes[ch].clear |=> fillLvl[ch] == '0);

    // R9
    a_r9_high_follows_low: assert property (@(posedge clk) disable iff (!rstN)
      strobes[ch].pushHi |-> $past(strobes[ch].pushLo));
  end

  // R8
  a_r8_gated_by_master: assert property (@(posedge clk) disable iff (!rstN)
    !masterEn |=> reqValid == 2'b00);

  // R7
  a_r7_req_needs_timer: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid != 2'b00) |-> ($past(timerOvf) != 2'b00 && $past(masterEn)));

  // R7
  a_r7_addr_a: assert property (@(posedge clk) disable iff (!rstN)
    reqAddrA == (reqValid[0] ? FIFO_A_ADDR : '0));

  // R7
  a_r7_addr_b: assert property (@(posedge clk) disable iff (!rstN)
    reqAddrB == (reqValid[1] ? FIFO_B_ADDR : '0));

  // R5
  a_r5_unused_bits_zero: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlRdData & ~CTRL_KEEP_MASK) == 16'h0000);

endmodule

bind dsound_fifo_pair dsound_checker #(
  .DEPTH      (DEPTH),
  .ADDR_W     (ADDR_W),
  .FIFO_A_ADDR(FIFO_A_ADDR),
  .FIFO_B_ADDR(FIFO_B_ADDR)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .masterEn  (masterEn),
  .ctrlRdData(ctrlRdData),
  .timerOvf  (timerOvf),
  .reqValid  (reqValid),
  .reqAddrA  (reqAddrA),
  .reqAddrB  (reqAddrB),
  .strobes   (strobes),
  .samples   (samples),
  .fillLvl   (fillLvl)
);

// File: tb/dsound_fifo_pair_tb.sv
module dsound_fifo_pair_tb;

  localparam logic [31:0] ADDR_A = 32'h0000_1000;
  localparam logic [31:0] ADDR_B = 32'h0000_1004;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        masterEn = 1'b0;
  logic        ctrlWrEn = 1'b0;
  logic [15:0] ctrlWrData = '0;
  logic [15:0] ctrlRdData;
  logic [1:0]  fifoWrEn = '0;
  logic [15:0] fifoWrData = '0;
  logic [1:0]  popTick = '0;
  logic [7:0]  sampleA;
  logic [7:0]  sampleB;
  logic [1:0]  timerOvf = '0;
  logic [1:0]  reqValid;
  logic [31:0] reqAddrA;
  logic [31:0] reqAddrB;

  int nChecks = 0;
  int nBad = 0;

  always #5 clk = ~clk;

  dsound_fifo_pair #(
    .FIFO_A_ADDR(ADDR_A),
    .FIFO_B_ADDR(ADDR_B)
  ) u_dut (
    .clk(clk), .rstN(rstN), .masterEn(masterEn),
    .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData), .ctrlRdData(ctrlRdData),
    .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData), .popTick(popTick),
    .sampleA(sampleA), .sampleB(sampleB), .timerOvf(timerOvf),
    .reqValid(reqValid), .reqAddrA(reqAddrA), .reqAddrB(reqAddrB)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ctrlWr(input logic [15:0] d);
    @(negedge clk);
    ctrlWrEn = 1'b1;
    ctrlWrData = d;
    @(negedge clk);
    ctrlWrEn = 1'b0;
  endtask

  task automatic portWr(input int ch, input logic [15:0] d);
    @(negedge clk);
    fifoWrEn[ch] = 1'b1;
    fifoWrData = d;
    @(negedge clk);
    fifoWrEn[ch] = 1'b0;
    @(negedge clk);
  endtask

  task automatic popS(input int ch, output logic [7:0] v);
    @(negedge clk);
    popTick[ch] = 1'b1;
    @(negedge clk);
    popTick[ch] = 1'b0;
    v = (ch == 0) ? sampleA : sampleB;
  endtask

  task automatic popExpect(input int ch, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    popS(ch, v);
    chk(tag, {24'h0, v}, {24'h0, exp});
  endtask

  task automatic ovfPulse(input logic [1:0] ovf, input logic [1:0] expReq, input string tag);
    @(negedge clk);
    timerOvf = ovf;
    @(negedge clk);
    timerOvf = '0;
    chk({tag, " req"}, {30'h0, reqValid}, {30'h0, expReq});
    chk({tag, " addrA"}, reqAddrA, expReq[0] ? ADDR_A : 32'h0);
    chk({tag, " addrB"}, reqAddrB, expReq[1] ? ADDR_B : 32'h0);
    @(negedge clk);
    chk({tag, " pulse ends"}, {30'h0, reqValid}, 32'h0);
  endtask

  task automatic t_reset();
    chk("R1 ctrl readback", {16'h0, ctrlRdData}, 32'h0);
    chk("R1 sampleA", {24'h0, sampleA}, 32'h0);
    chk("R1 sampleB", {24'h0, sampleB}, 32'h0);
    chk("R1 requests", {30'h0, reqValid}, 32'h0);
    popExpect(0, 8'h00, "R1 queue A empty");
    popExpect(1, 8'h00, "R1 queue B empty");
  endtask

  task automatic t_order();
    ctrlWr(16'h8800);
    portWr(0, 16'h2211);
    portWr(0, 16'hC433);
    popExpect(0, 8'h11, "R2 first low byte");
    popExpect(0, 8'h22, "R2 first high byte");
    popExpect(0, 8'h33, "R2 second low byte");
    popExpect(0, 8'hC4, "R2 second high byte");
    repeat (3) @(negedge clk);
    chk("R2 output holds", {24'h0, sampleA}, 32'hC4);
  endtask

  task automatic t_empty();
    ctrlWr(16'h8800);
    popExpect(1, 8'h00, "R4 empty pop");
    popExpect(1, 8'h00, "R4 second empty pop");
    portWr(1, 16'h0605);
    popExpect(1, 8'h05, "R4 pointers unmoved low");
    popExpect(1, 8'h06, "R4 pointers unmoved high");
    popExpect(1, 8'h00, "R4 empty again");
  endtask

  task automatic t_full();
    ctrlWr(16'h8800);
    for (int i = 0; i < 17; i++) portWr(0, {8'(2 * i + 1), 8'(2 * i)});
    for (int k = 0; k < 32; k++) popExpect(0, 8'(k), $sformatf("R3 entry %0d", k));
    popExpect(0, 8'h00, "R3 extra pushes dropped");
  endtask

  task automatic t_ctrl();
    ctrlWr(16'hFFFF);
    chk("R5 all ones readback", {16'h0, ctrlRdData}, 32'h770C);
    ctrlWr(16'h0507);
    chk("R5 partial readback", {16'h0, ctrlRdData}, 32'h0504);
    ctrlWr(16'h0000);
    chk("R5 cleared readback", {16'h0, ctrlRdData}, 32'h0);
  endtask

  task automatic t_flush();
    ctrlWr(16'h8800);
    portWr(0, 16'hA2A1);
    portWr(1, 16'hB2B1);
    ctrlWr(16'h0800);
    popExpect(0, 8'h00, "R6 queue A flushed");
    popExpect(1, 8'hB1, "R10 queue B kept low");
    ctrlWr(16'h8000);
    popExpect(1, 8'h00, "R6 queue B flushed");
    portWr(0, 16'h0D0C);
    popExpect(0, 8'h0C, "R6 reuse after flush");
  endtask

  task automatic t_req();
    masterEn = 1'b1;
    ctrlWr(16'h4000);
    ovfPulse(2'b01, 2'b01, "R7 timer0 to A");
    ovfPulse(2'b10, 2'b10, "R7 timer1 to B");
    ovfPulse(2'b11, 2'b11, "R7 both timers");
    ctrlWr(16'h4400);
    ovfPulse(2'b10, 2'b11, "R7 both select timer1");
    ovfPulse(2'b01, 2'b00, "R7 timer0 unused");
  endtask

  task automatic t_master();
    masterEn = 1'b0;
    ovfPulse(2'b11, 2'b00, "R8 master off");
    masterEn = 1'b1;
    ovfPulse(2'b10, 2'b11, "R8 master back on");
  endtask

  task automatic t_backtoback();
    ctrlWr(16'h8800);
    @(negedge clk);
    fifoWrEn[0] = 1'b1;
    fifoWrData = 16'h2211;
    @(negedge clk);
    fifoWrData = 16'h4433;
    @(negedge clk);
    fifoWrEn[0] = 1'b0;
    @(negedge clk);
    popExpect(0, 8'h11, "R9 first low");
    popExpect(0, 8'h22, "R9 first high");
    popExpect(0, 8'h00, "R9 second write dropped");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nBad++;
    $display("FAIL R1 watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_empty();
    t_full();
    t_ctrl();
    t_flush();
    t_req();
    t_master();
    t_backtoback();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

endmodule